// File: doc/BRIEF.md
# Lock-Guarded Watchdog Timer

This block is a memory-mapped watchdog. Software programs a reload value, starts a down-counter that advances on each pulse of a count-enable tick, and must acknowledge the interrupt that fires when the counter runs out. If the counter runs out a second time while that interrupt is still unacknowledged, the block raises a reset request, which stays asserted until the system reset clears it.

All register writes except those to the key register are gated by a write guard. Writing the unlock key opens the guard, and writing any other word to the key register closes it. Acknowledging the interrupt also restarts the count, so a single write serves as the periodic "kick".

The alarm logic is a four-state machine:
- `ALM_QUIET`: no interrupt is pending and no reset is requested.
- `ALM_PENDING`: an interrupt is pending.
- `ALM_TRIPPED`: an interrupt is pending and a reset is requested.
- `ALM_TRIPPED_CLR`: a reset is requested but the interrupt has been acknowledged.

Its transitions are:
- QUIET→PENDING on expiry.
- PENDING→QUIET on acknowledge.
- PENDING→TRIPPED on expiry when reset is enabled.
- TRIPPED→TRIPPED_CLR on acknowledge.
- TRIPPED_CLR→TRIPPED on expiry.

Every other case holds the current state.

Top module: `wdt_guard`

## Requirements
- R1: After reset, the reload, count and control registers all read 0, `irq` is 0 and `sys_rst_req` is 0. The key register reads 0 (unlocked) unless `LOCK_AT_RESET`=1.
- R2: Writing 32'h1ACCE551 to offset 0xC00 unlocks the guard, after which 0xC00 reads 0. Writing any other value to 0xC00 locks it, after which 0xC00 reads 1.
- R3: While locked, writes to offsets 0x000, 0x008 and 0x00C change neither the reload value, the control bits, the count nor the interrupt.
- R4: A write to 0x000 sets the reload value and loads the counter with it in the same edge. A control write that changes bit 0 from 0 to 1 loads the counter from the reload value.
- R5: While control bit 0 (run) is 1, the counter decrements by one on each edge with `tick`=1. While run is 0 it holds its value. If a bus load and a tick fall on the same edge, the load wins.
- R6: On a tick with run=1 and the count at 1 or 0, the timer expires: the counter reloads and the interrupt becomes pending. Reload N therefore expires on the N-th tick, and a reload of 0 expires on every tick.
- R7: `irq` equals the pending-interrupt state ANDed with control bit 0. Clearing run hides the interrupt without acknowledging it.
- R8: An expiry while the interrupt is already pending asserts `sys_rst_req` only if control bit 1 is 1. Once asserted, `sys_rst_req` stays 1 until `rst_n` is asserted, even if the interrupt is acknowledged.
- R9: A write of any data to 0x00C clears the pending interrupt and reloads the counter from the reload value.
- R10: The read map is: 0x004 returns the live count, 0x008 returns only bits [1:0] with all higher bits 0, 0x00C reads 0, and any unmapped offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count-enable pulse from the slow timebase |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt output |
| sys_rst_req | output | 1 | Sticky reset request |

## Verification
A write or a tick applied before rising edge k takes effect at edge k. The register state, the count, `irq` and `sys_rst_req` are therefore valid from just after edge k, while `bus_rdata` follows `bus_addr` within the same cycle.

The bench drives inputs 1 ns after a rising edge and samples every output at the following falling edge. It compares them there against a behavioural model updated at the same rising edge. Directed reads set the address one cycle after the stimulus, with the tick held low, so each hand-computed value is taken after exactly the intended number of ticks.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_RELOAD = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_COUNT  = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_ACK    = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_KEY    = 12'hC00;

    localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACC_E551;

    typedef enum logic [1:0] {
        ALM_QUIET       = 2'd0,
        ALM_PENDING     = 2'd1,
        ALM_TRIPPED     = 2'd2,
        ALM_TRIPPED_CLR = 2'd3
    } alarm_state_t;
endpackage

// File: rtl/wdt_guard_regs.sv
module wdt_guard_regs
    import wdt_guard_pkg::*;
#(
    parameter int CNT_W         = 32,
    parameter bit LOCK_AT_RESET = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  cnt_val,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [CNT_W-1:0]  reload_q,
    output logic              run_en,
    output logic              rst_en,
    output logic              load,
    output logic [CNT_W-1:0]  load_val,
    output logic              ack
);
    logic locked_q;
    logic wr_any, wr_key, wr_reload, wr_ctrl, wr_ack;

    assign wr_any    = bus_valid & bus_write;
    assign wr_key    = wr_any && (bus_addr == OFS_KEY);
    assign wr_reload = wr_any && !locked_q && (bus_addr == OFS_RELOAD);
    assign wr_ctrl   = wr_any && !locked_q && (bus_addr == OFS_CTRL);
    assign wr_ack    = wr_any && !locked_q && (bus_addr == OFS_ACK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            locked_q <= LOCK_AT_RESET;
            reload_q <= '0;
            run_en   <= 1'b0;
            rst_en   <= 1'b0;
        end else begin
            if (wr_key)
                locked_q <= (bus_wdata != UNLOCK_KEY);
            if (wr_reload)
                reload_q <= bus_wdata[CNT_W-1:0];
            if (wr_ctrl) begin
                run_en <= bus_wdata[0];
                rst_en <= bus_wdata[1];
            end
        end
    end

    assign load     = wr_reload | wr_ack | (wr_ctrl & bus_wdata[0] & ~run_en);
    assign load_val = wr_reload ? bus_wdata[CNT_W-1:0] : reload_q;
    assign ack      = wr_ack;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_RELOAD: bus_rdata[CNT_W-1:0] = reload_q;
            OFS_COUNT:  bus_rdata[CNT_W-1:0] = cnt_val;
            OFS_CTRL:   bus_rdata[1:0]       = {rst_en, run_en};
            OFS_KEY:    bus_rdata[0]         = locked_q;
            default:    bus_rdata            = '0;
        endcase
    end

    // R3: a locked write to any guarded offset leaves the configuration untouched
    p_locked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_q && wr_any && bus_addr != OFS_KEY)
            |=> ($stable(reload_q) && $stable(run_en) && $stable(rst_en)));
endmodule

// File: rtl/wdt_guard_counter.sv
module wdt_guard_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run_en,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // The count at 1, or at 0 for a zero reload, is the last tick before expiry.
    assign expire = run_en && tick && !load && (cnt_q[CNT_W-1:1] == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (run_en && tick) begin
            if (expire)
                cnt_q <= reload_val;
            else
                cnt_q <= cnt_q - ONE;
        end
    end

    // R5: no run and no load -> the count holds
    p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !load) |=> $stable(cnt_q));

    // R5: an ordinary tick moves the count down by exactly one
    p_step_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && tick && !load && !expire) |=> (cnt_q == $past(cnt_q) - ONE));

    // R6: expiry restarts from the reload value
    p_reload_expire_r6: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (cnt_q == $past(reload_val)));
endmodule

// File: rtl/wdt_guard_alarm.sv
module wdt_guard_alarm
    import wdt_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic ack,
    input  logic rst_en,
    output logic flag,
    output logic sys_rst
);
    alarm_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ALM_QUIET;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ALM_QUIET:
                if (expire) state_d = ALM_PENDING;
            ALM_PENDING:
                if (ack) state_d = ALM_QUIET;
                else if (expire && rst_en) state_d = ALM_TRIPPED;
            ALM_TRIPPED:
                if (ack) state_d = ALM_TRIPPED_CLR;
            ALM_TRIPPED_CLR:
                if (expire) state_d = ALM_TRIPPED;
        endcase
    end

    always_comb begin
        flag    = (state_q == ALM_PENDING) || (state_q == ALM_TRIPPED);
        sys_rst = (state_q == ALM_TRIPPED) || (state_q == ALM_TRIPPED_CLR);
    end

    // R8: the reset request never drops until rst_n
    p_rst_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |=> sys_rst);

    // R8: reset rises only on an expiry that finds the interrupt pending with reset enabled
    p_rst_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sys_rst && !(expire && flag && rst_en)) |=> !sys_rst);

    // R9: acknowledge clears the pending interrupt
    p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !flag);

    // R6: expiry leaves the interrupt pending
    p_expire_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> flag);
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
    import wdt_guard_pkg::*;
#(
    parameter int CNT_W         = 32,
    parameter bit LOCK_AT_RESET = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              sys_rst_req
);
    logic [CNT_W-1:0] reload_q, load_val, cnt_q;
    logic             run_en, rst_en, load, ack, expire, flag;

    wdt_guard_regs #(.CNT_W(CNT_W), .LOCK_AT_RESET(LOCK_AT_RESET)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cnt_val   (cnt_q),
        .bus_rdata (bus_rdata),
        .reload_q  (reload_q),
        .run_en    (run_en),
        .rst_en    (rst_en),
        .load      (load),
        .load_val  (load_val),
        .ack       (ack)
    );

    wdt_guard_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .run_en     (run_en),
        .load       (load),
        .load_val   (load_val),
        .reload_val (reload_q),
        .cnt_q      (cnt_q),
        .expire     (expire)
    );

    wdt_guard_alarm u_alarm (
        .clk     (clk),
        .rst_n   (rst_n),
        .expire  (expire),
        .ack     (ack),
        .rst_en  (rst_en),
        .flag    (flag),
        .sys_rst (sys_rst_req)
    );

    assign irq = flag & run_en;

    // R7: with run off no interrupt is visible
    p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |-> !irq);
endmodule

// File: tb/sim_wdt_guard.sv
module sim_wdt_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, sys_rst_req;

    int checks = 0;
    int errs = 0;
    int cyc_n = 0;
    bit live = 1'b0;

    // behavioural reference state
    logic [31:0] m_reload, m_cnt;
    bit m_locked, m_en, m_ren, m_flag, m_rst;

    wdt_guard u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_valid(bus_valid),
        .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .sys_rst_req(sys_rst_req)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [11:0] a);
        case (a)
            12'h000: return m_reload;
            12'h004: return m_cnt;
            12'h008: return {30'd0, m_ren, m_en};
            12'hC00: return {31'd0, m_locked};
            default: return 32'd0;
        endcase
    endfunction

    // reference model, updated on the same edge as the design
    always @(posedge clk) begin
        if (!rst_n) begin
            m_reload = 0; m_cnt = 0; m_locked = 0;
            m_en = 0; m_ren = 0; m_flag = 0; m_rst = 0;
        end else begin
            bit loaded;
            loaded = 0;
            if (bus_valid && bus_write) begin
                if (bus_addr == 12'hC00)
                    m_locked = (bus_wdata != 32'h1ACCE551);
                else if (!m_locked) begin
                    if (bus_addr == 12'h000) begin
                        m_reload = bus_wdata; m_cnt = bus_wdata; loaded = 1;
                    end else if (bus_addr == 12'h008) begin
                        if (bus_wdata[0] && !m_en) begin m_cnt = m_reload; loaded = 1; end
                        m_en = bus_wdata[0]; m_ren = bus_wdata[1];
                    end else if (bus_addr == 12'h00C) begin
                        m_flag = 0; m_cnt = m_reload; loaded = 1;
                    end
                end
            end
            if (!loaded && m_en && tick) begin
                if (m_cnt <= 1) begin
                    m_cnt = m_reload;
                    if (m_flag && m_ren) m_rst = 1;
                    m_flag = 1;
                end else
                    m_cnt = m_cnt - 1;
            end
        end
    end

    // every-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && live) begin
            chk(irq == (m_flag & m_en), "R7 irq vs model", {31'd0, irq}, {31'd0, m_flag & m_en});
            chk(sys_rst_req == m_rst, "R8 reset vs model", {31'd0, sys_rst_req}, {31'd0, m_rst});
            chk(bus_rdata == exp_rd(bus_addr), "R10 rdata vs model", bus_rdata, exp_rd(bus_addr));
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    endtask

    always @(posedge clk) begin
        cyc_n++;
        if (cyc_n > 20000) begin
            errs++;
            $display("FAIL watchdog all-reqs act=%0d exp<=%0d", cyc_n, 20000);
            summary();
            $finish;
        end
    end

    task automatic cyc(input bit v, input bit w, input logic [11:0] a, input logic [31:0] d, input bit t);
        @(posedge clk); #1;
        bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d; tick = t;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        cyc(1, 1, a, d, 0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 12'h004, 0, 1);
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
        cyc(0, 0, a, 0, 0);
        @(negedge clk);
        chk(bus_rdata == exp, tag, bus_rdata, exp);
    endtask

    task automatic out_chk(input bit ei, input bit er, input string tag);
        cyc(0, 0, 12'h004, 0, 0);
        @(negedge clk);
        chk(irq == ei, {tag, " irq"}, {31'd0, irq}, {31'd0, ei});
        chk(sys_rst_req == er, {tag, " sys_rst_req"}, {31'd0, sys_rst_req}, {31'd0, er});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1; live = 1'b1;
        // R1 reset state
        rd_chk(12'h000, 0, "R1 reload after reset");
        rd_chk(12'h004, 0, "R1 count after reset");
        rd_chk(12'h008, 0, "R1 ctrl after reset");
        rd_chk(12'hC00, 0, "R1 key reads unlocked");
        out_chk(0, 0, "R1 outputs after reset");
        // R4 reload write loads counter
        wr(12'h000, 5);
        rd_chk(12'h004, 5, "R4 reload write loads count");
        wr(12'h008, 1);
        rd_chk(12'h004, 5, "R4 enable loads count");
        ticks(4);
        rd_chk(12'h004, 1, "R5 four ticks decrement");
        ticks(1);
        out_chk(1, 0, "R6 expiry on fifth tick");
        rd_chk(12'h004, 5, "R6 reload on expiry");
        ticks(2);
        wr(12'h008, 0);
        out_chk(0, 0, "R7 irq masked by run=0");
        ticks(3);
        rd_chk(12'h004, 3, "R5 count holds while stopped");
        wr(12'h008, 1);
        rd_chk(12'h004, 5, "R4 rising run reloads");
        out_chk(1, 0, "R7 pending survives stop");
        wr(12'h00C, 32'hDEAD_BEEF);
        out_chk(0, 0, "R9 acknowledge clears irq");
        rd_chk(12'h004, 5, "R9 acknowledge reloads");
        // R8 escalation
        ticks(10);
        out_chk(1, 0, "R8 no reset when bit1=0");
        wr(12'h008, 3);
        ticks(5);
        out_chk(1, 1, "R8 second expiry escalates");
        wr(12'h00C, 0);
        out_chk(0, 1, "R8 reset sticky over acknowledge");
        // R2/R3 guard
        ticks(2);
        wr(12'hC00, 32'h1234_5678);
        rd_chk(12'hC00, 1, "R2 other word locks");
        wr(12'h000, 7);
        rd_chk(12'h000, 5, "R3 locked reload write ignored");
        wr(12'h008, 0);
        rd_chk(12'h008, 3, "R3 locked ctrl write ignored");
        wr(12'h00C, 1);
        rd_chk(12'h004, 3, "R3 locked acknowledge ignored");
        wr(12'hC00, 32'h1ACC_E551);
        rd_chk(12'hC00, 0, "R2 key unlocks");
        // R6 zero reload
        wr(12'h000, 0);
        ticks(1);
        out_chk(1, 1, "R6 zero reload expires on first tick");
        rd_chk(12'h004, 0, "R6 zero reload count");
        // R10 read map
        wr(12'h008, 32'hFFFF_FFFF);
        rd_chk(12'h008, 3, "R10 ctrl reserved bits zero");
        rd_chk(12'h00C, 0, "R10 ack offset reads zero");
        rd_chk(12'h010, 0, "R10 unmapped reads zero");
        // R5 load beats tick
        cyc(1, 1, 12'h000, 3, 1);
        rd_chk(12'h004, 3, "R5 load wins over tick");
        ticks(7);
        rd_chk(12'h004, 2, "R6 periodic reload of 3");
        // reset clears sticky request
        @(posedge clk); #1 rst_n = 1'b0;
        @(negedge clk);
        chk(sys_rst_req == 0, "R1 sys_rst_req cleared by rst_n", {31'd0, sys_rst_req}, 0);
        chk(irq == 0, "R1 irq cleared by rst_n", {31'd0, irq}, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        rd_chk(12'h000, 0, "R1 reload after second reset");
        summary();
        $finish;
    end
endmodule